// File: doc/BRIEF.md
# Flash Hardware Sequencer Controller

This block runs complete serial-flash operations without further software help. Software programs a flash address, optionally fills a 64-byte data buffer, and then writes one control word. That word holds a cycle-type code, a byte count and a go bit. The block then checks the target address with an external protection lookup and issues a single command to a SPI shifter. The command carries the opcode, the address and the transfer length. The block then waits for the shifter's completion response.

While a command runs, the shifter reads bytes out of the buffer for program-type cycles and writes bytes into it for read-type cycles. It addresses the buffer through a byte index. The outcome is reported in sticky status flags that software clears by writing ones: done, error and access-denied. A lockable interrupt-enable bit gates an interrupt line on the done flag.

The register port is a plain 32-bit write strobe with a combinational read mux, selected by a word index:

| Word index | Register |
|---|---|
| 0 | Control/status |
| 1 | Flash address |
| 2 to 17 | Data words 0 to 15 |

Top module: `flash_hwseq`

## Requirements
- R1: After reset, the control/status word, the address register and every data word read 0, and `cmd_valid` and `irq` are low.
- R2: A go write (bit 16) with a supported cycle type in bits 20:17 issues exactly one `cmd_valid` pulse, in the cycle after the write edge, with opcode 0x03 for type 0 (read), 0x02 for 2 (write), 0x20 for 3 (4 KiB erase), 0xD8 for 4 (64 KiB erase), 0x9F for 6 (read ID), 0x01 for 7 (write status) and 0x05 for 8 (read status).
- R3: For types 0, 2, 6, 7 and 8, `cmd_len` is the count in bits 29:24 plus one. Type 3 gives a length of 4096 and type 4 gives 65536, with the count ignored. The address is passed through for types 0 and 2, cleared to its 4 KiB or 64 KiB boundary for erases, and driven 0 for types 6, 7 and 8.
- R4: The in-progress flag (bit 5) reads 1 from the edge that accepts a go until the edge that samples `rsp_done`. On that same edge it falls and the done flag (bit 0) rises.
- R5: A go with any other type code sets the error flag (bit 1) on the write edge, leaves bit 5 low and issues no command.
- R6: While bit 5 is high, writes to the go bit, to the type and count fields, to the address register and to the data words are ignored.
- R7: Writing 1 to bit 0, 1 or 2 clears that flag; writing 0 leaves it unchanged.
- R8: `rsp_err` sampled together with `rsp_done` sets the error flag along with done.
- R9: During the check cycle `prot_req` is high and `prot_write` marks types 2, 3, 4 and 7. A high `prot_deny` suppresses the command and sets the access flag (bit 2) and done on the next edge, with bit 5 falling.
- R10: A byte strobed by `sh_rvld` at index i lands in data word i/4, bits 8*(i%4)+7:8*(i%4), and is readable once done is set.
- R11: `sh_wbyte` is the buffer byte at `sh_idx`, using the same byte order as R10.
- R12: The lock flag (bit 15) can be set but not cleared until reset. Once it reads 1, the interrupt-enable bit (bit 31) no longer changes.
- R13: `irq` is high exactly when interrupt-enable and done are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| cmd_valid | output | 1 | One-cycle command start to the shifter |
| cmd_op | output | 8 | Flash opcode |
| cmd_addr | output | 24 | Flash address of the command |
| cmd_len | output | 17 | Bytes transferred or erased |
| sh_idx | input | 6 | Buffer byte index used by the shifter |
| sh_wbyte | output | 8 | Buffer byte at `sh_idx` |
| sh_rvld | input | 1 | Store `sh_rbyte` at `sh_idx` |
| sh_rbyte | input | 8 | Byte returned from flash |
| rsp_done | input | 1 | Shifter completion |
| rsp_err | input | 1 | Shifter failure, valid with `rsp_done` |
| prot_req | output | 1 | Protection lookup request |
| prot_addr | output | 24 | Address under lookup |
| prot_write | output | 1 | Lookup concerns a modifying cycle |
| prot_deny | input | 1 | Same-cycle lookup refusal |
| irq | output | 1 | Interrupt line |

## Verification
Four results are due at fixed cycles:
- A go is accepted on its write edge, so bit 5 and `prot_req` read high in the following cycle, together with the command pulse and its opcode, length and address.
- An unsupported code shows its error flag in the cycle right after the write edge.
- A denial shows the access flag one edge after the check cycle.
- Completion shows bit 5 low and done high one edge after `rsp_done` is driven.

The bench drives every input half a period before the edge and reads every output half a period after it. It confirms each result in the expected cycle, and also confirms the value one cycle earlier, for example done still low while `rsp_done` is pending. Command pulses are counted at the clock edge, so a missing or repeated pulse is caught regardless of when it occurs.

// File: rtl/flash_hwseq_pkg.sv
package flash_hwseq_pkg;
   localparam int CSR_DONE    = 0;
   localparam int CSR_ERR     = 1;
   localparam int CSR_AEL     = 2;
   localparam int CSR_BUSY    = 5;
   localparam int CSR_LOCK    = 15;
   localparam int CSR_GO      = 16;
   localparam int CSR_TYPE_LO = 17;
   localparam int CSR_CNT_LO  = 24;
   localparam int CSR_IE      = 31;

   typedef enum logic [1:0] {KIND_XFER, KIND_REGX, KIND_ER4K, KIND_ER64K} cyc_kind_e;

   typedef struct packed {
      logic       valid;
      logic       modifies;
      cyc_kind_e  kind;
      logic [7:0] opcode;
   } cyc_info_t;

   typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_WAIT} seq_state_e;
endpackage

// File: rtl/fhs_cycle_decode.sv
module fhs_cycle_decode
   import flash_hwseq_pkg::*;
(
   input  logic [3:0] ctype,
   output cyc_info_t  info
);
   always_comb begin
      info.valid    = 1'b1;
      info.modifies = 1'b0;
      info.kind     = KIND_XFER;
      info.opcode   = 8'h03;
      case (ctype)
         4'd0: ;
         4'd2: begin info.opcode = 8'h02; info.modifies = 1'b1; end
         4'd3: begin info.opcode = 8'h20; info.modifies = 1'b1; info.kind = KIND_ER4K; end
         4'd4: begin info.opcode = 8'hD8; info.modifies = 1'b1; info.kind = KIND_ER64K; end
         4'd6: begin info.opcode = 8'h9F; info.kind = KIND_REGX; end
         4'd7: begin info.opcode = 8'h01; info.modifies = 1'b1; info.kind = KIND_REGX; end
         4'd8: begin info.opcode = 8'h05; info.kind = KIND_REGX; end
         default: info.valid = 1'b0;
      endcase
   end
endmodule

// File: rtl/fhs_databuf.sv
module fhs_databuf #(
   parameter int WORDS  = 16,
   localparam int BYTES  = WORDS * 4,
   localparam int IDX_W  = $clog2(BYTES),
   localparam int WSEL_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WSEL_W-1:0] wr_word,
   input  logic [31:0]       wr_data,
   input  logic              fill_en,
   input  logic [IDX_W-1:0]  byte_idx,
   input  logic [7:0]        fill_byte,
   input  logic [WSEL_W-1:0] rd_word,
   output logic [31:0]       rd_data,
   output logic [7:0]        peek_byte
);
   logic [7:0] lane [BYTES];

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      for (genvar b = 0; b < 4; b++) begin : g_lane
         logic [7:0] lane_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               lane_q <= '0;
            else if (wr_en && wr_word == WSEL_W'(w))
               lane_q <= wr_data[8*b +: 8];
            else if (fill_en && byte_idx[IDX_W-1:2] == WSEL_W'(w) && byte_idx[1:0] == 2'(b))
               lane_q <= fill_byte;
         end
         assign lane[w*4 + b] = lane_q;
      end
   end

   assign rd_data   = {lane[{rd_word, 2'd3}], lane[{rd_word, 2'd2}],
                       lane[{rd_word, 2'd1}], lane[{rd_word, 2'd0}]};
   assign peek_byte = lane[byte_idx];

   // R10: a strobed byte is present in its lane on the next cycle
   p_fill_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && !wr_en) |=> lane[$past(byte_idx)] == $past(fill_byte));
endmodule

// File: rtl/fhs_ctrl.sv
module fhs_ctrl
   import flash_hwseq_pkg::*;
#(
   parameter int FLASH_AW = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                csr_wr,
   input  logic [31:0]         csr_wdata,
   input  cyc_info_t           new_info,
   input  logic [FLASH_AW-1:0] faddr,
   input  logic                prot_deny,
   input  logic                rsp_done,
   input  logic                rsp_err,
   output logic [31:0]         csr_rdata,
   output logic                busy,
   output logic                fill_ok,
   output logic                cmd_valid,
   output logic [7:0]          cmd_op,
   output logic [FLASH_AW-1:0] cmd_addr,
   output logic [16:0]         cmd_len,
   output logic                prot_req,
   output logic                prot_write,
   output logic                irq
);
   seq_state_e state_q;
   cyc_kind_e  kind_q;
   logic [7:0] op_q;
   logic [5:0] cnt_q;
   logic [3:0] type_q;
   logic       mod_q, ie_q, lock_q, done_q, err_q, ael_q;
   logic       go_w, start, bad, deny_hit, fin, unused_bits;

   assign unused_bits = ^{csr_wdata[30], csr_wdata[23:21], csr_wdata[14:3]};

   assign busy     = (state_q != ST_IDLE);
   assign fill_ok  = (state_q == ST_WAIT);
   assign go_w     = csr_wr && csr_wdata[CSR_GO];
   assign start    = go_w && !busy && new_info.valid;
   assign bad      = go_w && !busy && !new_info.valid;
   assign deny_hit = (state_q == ST_CHECK) && prot_deny;
   assign fin      = (state_q == ST_WAIT) && rsp_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         kind_q  <= KIND_XFER;
         op_q    <= '0;
         mod_q   <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE:  if (start) state_q <= ST_CHECK;
            ST_CHECK: state_q <= prot_deny ? ST_IDLE : ST_WAIT;
            default:  if (rsp_done) state_q <= ST_IDLE;
         endcase
         if (start) begin
            kind_q <= new_info.kind;
            op_q   <= new_info.opcode;
            mod_q  <= new_info.modifies;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         type_q <= '0;
         ie_q   <= 1'b0;
         lock_q <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         ael_q  <= 1'b0;
      end else begin
         if (csr_wr && !busy) begin
            cnt_q  <= csr_wdata[CSR_CNT_LO +: 6];
            type_q <= csr_wdata[CSR_TYPE_LO +: 4];
            lock_q <= lock_q | csr_wdata[CSR_LOCK];
            if (!lock_q) ie_q <= csr_wdata[CSR_IE];
         end
         done_q <= (fin || deny_hit) || (done_q && !(csr_wr && csr_wdata[CSR_DONE]));
         err_q  <= (bad || (fin && rsp_err)) || (err_q && !(csr_wr && csr_wdata[CSR_ERR]));
         ael_q  <= deny_hit || (ael_q && !(csr_wr && csr_wdata[CSR_AEL]));
      end
   end

   always_comb begin
      case (kind_q)
         KIND_XFER: cmd_addr = faddr;
         KIND_REGX: cmd_addr = '0;
         KIND_ER4K: cmd_addr = {faddr[FLASH_AW-1:12], 12'h000};
         default:   cmd_addr = {faddr[FLASH_AW-1:16], 16'h0000};
      endcase
      case (kind_q)
         KIND_ER4K:  cmd_len = 17'd4096;
         KIND_ER64K: cmd_len = 17'd65536;
         default:    cmd_len = 17'(cnt_q) + 17'd1;
      endcase
   end

   assign cmd_valid  = (state_q == ST_CHECK) && !prot_deny;
   assign cmd_op     = op_q;
   assign prot_req   = (state_q == ST_CHECK);
   assign prot_write = mod_q;
   assign irq        = ie_q && done_q;

   always_comb begin
      csr_rdata                      = '0;
      csr_rdata[CSR_IE]              = ie_q;
      csr_rdata[CSR_CNT_LO +: 6]     = cnt_q;
      csr_rdata[CSR_TYPE_LO +: 4]    = type_q;
      csr_rdata[CSR_LOCK]            = lock_q;
      csr_rdata[CSR_BUSY]            = busy;
      csr_rdata[CSR_AEL]             = ael_q;
      csr_rdata[CSR_ERR]             = err_q;
      csr_rdata[CSR_DONE]            = done_q;
   end

   p_cmd_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);
   p_len_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && (kind_q == KIND_XFER || kind_q == KIND_REGX)) |-> (cmd_len >= 17'd1 && cmd_len <= 17'd64));
   p_done_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done_q);
   p_bad_type_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (go_w && !busy && !new_info.valid) |=> (!busy && err_q));
   p_go_while_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT) |=> ($stable(op_q) && $stable(type_q) && $stable(cnt_q)));
   p_deny_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_req && prot_deny) |-> !cmd_valid);
   p_lock_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> (lock_q && $stable(ie_q)));
endmodule

// File: rtl/flash_hwseq.sv
module flash_hwseq
   import flash_hwseq_pkg::*;
#(
   parameter int  DATA_WORDS = 16,
   parameter int  FLASH_AW   = 24,
   localparam int IDX_W      = $clog2(DATA_WORDS * 4),
   localparam int REG_W      = $clog2(DATA_WORDS + 2),
   localparam int WSEL_W     = $clog2(DATA_WORDS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic [REG_W-1:0]    reg_addr,
   input  logic [31:0]         reg_wdata,
   output logic [31:0]         reg_rdata,
   output logic                cmd_valid,
   output logic [7:0]          cmd_op,
   output logic [FLASH_AW-1:0] cmd_addr,
   output logic [16:0]         cmd_len,
   input  logic [IDX_W-1:0]    sh_idx,
   output logic [7:0]          sh_wbyte,
   input  logic                sh_rvld,
   input  logic [7:0]          sh_rbyte,
   input  logic                rsp_done,
   input  logic                rsp_err,
   output logic                prot_req,
   output logic [FLASH_AW-1:0] prot_addr,
   output logic                prot_write,
   input  logic                prot_deny,
   output logic                irq
);
   initial begin
      assert (DATA_WORDS * 4 >= 64 && (1 << WSEL_W) == DATA_WORDS)
         else $fatal(1, "DATA_WORDS must be a power of two holding 64 bytes");
      assert (FLASH_AW > 16 && FLASH_AW <= 32)
         else $fatal(1, "FLASH_AW must lie in 17..32");
   end

   cyc_info_t             new_info;
   logic [31:0]           csr_rdata, buf_rdata;
   logic [FLASH_AW-1:0]   faddr_q;
   logic                  busy, fill_ok, csr_sel, addr_sel, data_sel;
   logic [WSEL_W-1:0]     buf_word;

   assign csr_sel  = (reg_addr == REG_W'(0));
   assign addr_sel = (reg_addr == REG_W'(1));
   assign data_sel = (reg_addr >= REG_W'(2)) && (reg_addr <= REG_W'(DATA_WORDS + 1));
   assign buf_word = WSEL_W'(reg_addr - REG_W'(2));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         faddr_q <= '0;
      else if (reg_wr && addr_sel && !busy)
         faddr_q <= reg_wdata[FLASH_AW-1:0];
   end

   fhs_cycle_decode u_decode (
      .ctype (reg_wdata[CSR_TYPE_LO +: 4]),
      .info  (new_info)
   );

   fhs_ctrl #(.FLASH_AW(FLASH_AW)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .csr_wr     (reg_wr && csr_sel),
      .csr_wdata  (reg_wdata),
      .new_info   (new_info),
      .faddr      (faddr_q),
      .prot_deny  (prot_deny),
      .rsp_done   (rsp_done),
      .rsp_err    (rsp_err),
      .csr_rdata  (csr_rdata),
      .busy       (busy),
      .fill_ok    (fill_ok),
      .cmd_valid  (cmd_valid),
      .cmd_op     (cmd_op),
      .cmd_addr   (cmd_addr),
      .cmd_len    (cmd_len),
      .prot_req   (prot_req),
      .prot_write (prot_write),
      .irq        (irq)
   );

   fhs_databuf #(.WORDS(DATA_WORDS)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr && data_sel && !busy),
      .wr_word   (buf_word),
      .wr_data   (reg_wdata),
      .fill_en   (sh_rvld && fill_ok),
      .byte_idx  (sh_idx),
      .fill_byte (sh_rbyte),
      .rd_word   (buf_word),
      .rd_data   (buf_rdata),
      .peek_byte (sh_wbyte)
   );

   assign prot_addr = cmd_addr;

   always_comb begin
      if (csr_sel)       reg_rdata = csr_rdata;
      else if (addr_sel) reg_rdata = 32'(faddr_q);
      else if (data_sel) reg_rdata = buf_rdata;
      else               reg_rdata = '0;
   end

   // R13: the interrupt never rises while the done flag reads 0
   p_irq_needs_done_r13: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> csr_rdata[CSR_DONE]);
endmodule

// File: tb/flash_hwseq_tb.sv
module flash_hwseq_tb;
   localparam int AW = 24;
   localparam int IW = 6;
   localparam int RW = 5;
   localparam logic [23:0] FADDR = 24'h123ABC;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [RW-1:0] reg_addr = '0;
   logic [31:0]   reg_wdata = '0, reg_rdata;
   logic          cmd_valid, prot_req, prot_write, irq;
   logic [7:0]    cmd_op, sh_wbyte;
   logic [AW-1:0] cmd_addr, prot_addr;
   logic [16:0]   cmd_len;
   logic [IW-1:0] sh_idx = '0;
   logic          sh_rvld = 1'b0, rsp_done = 1'b0, rsp_err = 1'b0, prot_deny = 1'b0;
   logic [7:0]    sh_rbyte = '0;

   always #10 clk = ~clk;

   flash_hwseq u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid),
      .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_len(cmd_len), .sh_idx(sh_idx),
      .sh_wbyte(sh_wbyte), .sh_rvld(sh_rvld), .sh_rbyte(sh_rbyte),
      .rsp_done(rsp_done), .rsp_err(rsp_err), .prot_req(prot_req),
      .prot_addr(prot_addr), .prot_write(prot_write), .prot_deny(prot_deny),
      .irq(irq)
   );

   int checks = 0, errors = 0, n_cmd = 0;
   bit ended = 0;

   always @(posedge clk) if (rst_n && cmd_valid) n_cmd <= n_cmd + 1;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
   end

   function automatic bit valid_t(int t);
      return t == 0 || t == 2 || t == 3 || t == 4 || t == 6 || t == 7 || t == 8;
   endfunction
   function automatic logic [7:0] exp_op(int t);
      case (t)
         0: return 8'h03;  2: return 8'h02;  3: return 8'h20;  4: return 8'hD8;
         6: return 8'h9F;  7: return 8'h01;  default: return 8'h05;
      endcase
   endfunction
   function automatic logic [31:0] exp_len(int t, int c);
      if (t == 3) return 32'd4096;
      if (t == 4) return 32'd65536;
      return 32'(c + 1);
   endfunction
   function automatic logic [31:0] exp_addr(int t);
      if (t == 0 || t == 2) return 32'(FADDR);
      if (t == 3) return 32'(FADDR & 24'hFFF000);
      if (t == 4) return 32'(FADDR & 24'hFF0000);
      return 32'd0;
   endfunction
   function automatic logic [7:0] pat(int i, int c);
      return 8'((i * 37 + c * 5 + 1) & 255);
   endfunction
   function automatic logic [31:0] pre(int w);
      return 32'h9E3779B9 ^ (32'(w) * 32'h01030507);
   endfunction
   function automatic logic [31:0] mk(int t, int c, bit go);
      return (32'(c) << 24) | (32'(t) << 17) | (32'(go) << 16);
   endfunction

   task automatic reg_write(input int idx, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = RW'(idx); reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input int idx, output logic [31:0] v);
      reg_addr = RW'(idx);
      #1 v = reg_rdata;
   endtask

   task automatic run(input int t, input int c, input bit deny, input bit rerr);
      logic [31:0] v;
      int n0 = n_cmd;
      bit m = (t == 2 || t == 3 || t == 4 || t == 7);
      reg_write(0, mk(t, c, 1'b1));
      reg_read(0, v);
      if (!valid_t(t)) begin
         chk("R5 err flag", 32'(v[1]), 32'd1);
         chk("R5 busy low", 32'(v[5]), 32'd0);
         @(negedge clk);
         chk("R5 no command", 32'(n_cmd), 32'(n0));
         return;
      end
      chk("R4 busy after go", 32'(v[5]), 32'd1);
      chk("R4 done low while busy", 32'(v[0]), 32'd0);
      chk("R9 prot_req", 32'(prot_req), 32'd1);
      chk("R9 prot_write", 32'(prot_write), 32'(m));
      if (deny) begin
         chk("R9 no cmd_valid", 32'(cmd_valid), 32'd0);
         @(negedge clk);
         reg_read(0, v);
         chk("R9 access flag", 32'(v[2]), 32'd1);
         chk("R9 done on deny", 32'(v[0]), 32'd1);
         chk("R9 busy drops", 32'(v[5]), 32'd0);
         chk("R9 command count", 32'(n_cmd), 32'(n0));
         return;
      end
      chk("R2 cmd_valid", 32'(cmd_valid), 32'd1);
      chk("R2 opcode", 32'(cmd_op), 32'(exp_op(t)));
      chk("R3 length", 32'(cmd_len), exp_len(t, c));
      chk("R3 address", 32'(cmd_addr), exp_addr(t));
      chk("R9 prot_addr", 32'(prot_addr), exp_addr(t));
      @(negedge clk);
      chk("R2 single pulse", 32'(cmd_valid), 32'd0);
      if (t == 0 || t == 6 || t == 8) begin
         for (int i = 0; i <= c; i++) begin
            sh_rvld = 1'b1; sh_idx = IW'(i); sh_rbyte = pat(i, c);
            @(negedge clk);
         end
         sh_rvld = 1'b0;
      end else if (t == 2 || t == 7) begin
         for (int i = 0; i <= c; i++) begin
            sh_idx = IW'(i);
            #1 chk("R11 write byte", 32'(sh_wbyte), (pre(i / 4) >> (8 * (i % 4))) & 32'hFF);
            @(negedge clk);
         end
      end else begin
         repeat (3) @(negedge clk);
      end
      rsp_done = 1'b1; rsp_err = rerr;
      reg_read(0, v);
      chk("R4 busy before response", 32'(v[5]), 32'd1);
      chk("R4 done before response", 32'(v[0]), 32'd0);
      @(negedge clk);
      rsp_done = 1'b0; rsp_err = 1'b0;
      reg_read(0, v);
      chk("R4 busy falls", 32'(v[5]), 32'd0);
      chk("R4 done rises", 32'(v[0]), 32'd1);
      chk("R8 error follows response", 32'(v[1]), 32'(rerr));
      chk("R2 one command", 32'(n_cmd), 32'(n0 + 1));
   endtask

   task automatic fill_data(input bit zero);
      for (int w = 0; w < 16; w++) reg_write(2 + w, zero ? 32'd0 : pre(w));
   endtask

   task automatic check_read_data(input int c);
      logic [31:0] v, e;
      for (int w = 0; w < 16; w++) begin
         @(negedge clk);
         reg_read(2 + w, v);
         e = '0;
         for (int b = 0; b < 4; b++)
            if (w * 4 + b <= c) e[8*b +: 8] = pat(w * 4 + b, c);
         chk("R10 read data word", v, e);
      end
   endtask

   initial begin
      logic [31:0] v;
      int n0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      reg_read(0, v);  chk("R1 control word", v, 32'd0);
      @(negedge clk);
      reg_read(1, v);  chk("R1 address", v, 32'd0);
      @(negedge clk);
      reg_read(2, v);  chk("R1 data first", v, 32'd0);
      @(negedge clk);
      reg_read(17, v); chk("R1 data last", v, 32'd0);
      chk("R1 cmd_valid", 32'(cmd_valid), 32'd0);
      chk("R1 irq", 32'(irq), 32'd0);

      reg_write(1, 32'(FADDR));
      for (int t = 0; t < 16; t++) begin
         for (int k = 0; k < 3; k++) begin
            int c = (t == 0 || t == 2) ? (k == 0 ? 0 : (k == 1 ? 5 : 63)) : 3;
            if (k > 0 && t != 0 && t != 2) continue;
            reg_write(0, 32'h7);
            if (t == 0 || t == 6 || t == 8) fill_data(1'b1);
            if (t == 2 || t == 7) fill_data(1'b0);
            run(t, c, 1'b0, 1'b0);
            if (t == 0 || t == 6 || t == 8) check_read_data(c);
         end
      end

      // R8: shifter failure
      reg_write(0, 32'h7);
      run(6, 1, 1'b0, 1'b1);

      // R7: write-one-to-clear, flags done=1 err=1 now
      reg_write(0, 32'h0);
      @(negedge clk); reg_read(0, v);
      chk("R7 zero write keeps flags", v & 32'h3, 32'h3);
      reg_write(0, 32'h2);
      reg_read(0, v);
      chk("R7 clear error only", v & 32'h3, 32'h1);
      reg_write(0, 32'h1);
      reg_read(0, v);
      chk("R7 clear done", v & 32'h7, 32'h0);

      // R9: protection denial on a 4K erase
      prot_deny = 1'b1;
      run(3, 0, 1'b1, 1'b0);
      prot_deny = 1'b0;
      reg_write(0, 32'h4);
      reg_read(0, v);
      chk("R7 clear access flag", v & 32'h4, 32'h0);

      // R6: writes while busy are ignored
      reg_write(0, 32'h7);
      reg_write(17, 32'h5555AAAA);
      n0 = n_cmd;
      reg_write(0, mk(0, 0, 1'b1));
      reg_write(0, mk(3, 9, 1'b1));
      reg_write(17, 32'h00001234);
      reg_write(1, 32'h0);
      @(negedge clk);
      sh_rvld = 1'b1; sh_idx = '0; sh_rbyte = 8'h66;
      @(negedge clk);
      sh_rvld = 1'b0; rsp_done = 1'b1;
      @(negedge clk);
      rsp_done = 1'b0;
      @(negedge clk);
      chk("R6 second go ignored", 32'(n_cmd), 32'(n0 + 1));
      reg_read(0, v);
      chk("R6 fields unchanged", v & 32'h3F1E0000, 32'h0);
      @(negedge clk); reg_read(17, v);
      chk("R6 data write ignored", v, 32'h5555AAAA);
      @(negedge clk); reg_read(1, v);
      chk("R6 address write ignored", v, 32'(FADDR));
      @(negedge clk); reg_read(2, v);
      chk("R10 byte lands in lane 0", v & 32'hFF, 32'h66);

      // R12 / R13: lock and interrupt enable
      reg_write(0, 32'h8000_0007);
      reg_read(0, v);
      chk("R12 enable set while unlocked", 32'(v[31]), 32'd1);
      chk("R13 irq low without done", 32'(irq), 32'd0);
      reg_write(0, 32'h8000_8000);
      reg_write(0, 32'h0000_0000);
      reg_read(0, v);
      chk("R12 lock stays set", 32'(v[15]), 32'd1);
      chk("R12 enable frozen", 32'(v[31]), 32'd1);
      run(8, 0, 1'b0, 1'b0);
      chk("R13 irq with done", 32'(irq), 32'd1);
      reg_write(0, 32'h1);
      #1 chk("R13 irq clears with done", 32'(irq), 32'd0);

      finish_run();
   end
endmodule